// File: doc/BRIEF.md
# CPU Endpoint FIFO Access Selector

This block gives a CPU one byte-wide data port through which it reaches any of four endpoint FIFOs. Two small join registers pick the endpoint: one for reading and one for writing. Each has one bit per endpoint. A read of the data port takes the oldest byte from the FIFO that is joined for reading. A write of the data port appends a byte to the FIFO that is joined for writing. Two 16-bit counters report how many bytes the read-joined FIFO holds and how much room the write-joined FIFO has left. The CPU can read each counter as a high byte and a low byte.

The four FIFOs sit inside the block as behavioural models with push and pop strobes and an occupancy count. An access FSM classifies every bus cycle. Its states are ST_IDLE, ST_REG_READ, ST_REG_WRITE, ST_POP, ST_PUSH, ST_NULL_READ, ST_NULL_WRITE, ST_UNDERRUN and ST_OVERRUN. The FSM picks its next state from the request in that cycle alone, so any state can move to any other:
- If cpu_wr is high and the address is the data port, the next state is ST_NULL_WRITE when no write endpoint is joined, ST_OVERRUN when the joined FIFO is full, and ST_PUSH otherwise.
- If cpu_wr is high and the address is anything else, the next state is ST_REG_WRITE.
- If only cpu_rd is high and the address is the data port, the next state is ST_NULL_READ when no read endpoint is joined, ST_UNDERRUN when the joined FIFO is empty, and ST_POP otherwise.
- If only cpu_rd is high and the address is anything else, the next state is ST_REG_READ.
- With no request, the next state is ST_IDLE.

Read data and cpu_rvalid appear in the cycle after the request. Register addresses:

| Address | Register |
|---|---|
| 0 | read join |
| 1 | write join |
| 2 | data port |
| 3 | read-remaining, high byte |
| 4 | read-remaining, low byte |
| 5 | write-remaining, high byte |
| 6 | write-remaining, low byte |
| 7 | reads 0 |

Top module: `ep_fifo_port_sel`

## Requirements
- R1: Each join register (address 0 for reading, address 1 for writing; bit n selects endpoint n) holds at most one set bit. The CPU can read back its value.
- R2: If a write to a join register has several bits set, only the highest-numbered set bit is kept. A write of 0 clears the join.
- R3: A read of the data port (address 2) while a read join is set pops one byte from that FIFO and returns the oldest byte. cpu_rdata and cpu_rvalid are valid in the next cycle. Popping is destructive, so a second read returns the next byte.
- R4: A write of the data port while a write join is set pushes cpu_wdata into that FIFO. If cpu_rd and cpu_wr are high in the same cycle, only the write is performed.
- R5: rd_remain gives the byte count of the read-joined FIFO. Its high byte is readable at address 3 and its low byte at address 4.
- R6: wr_remain gives FIFO_DEPTH minus the count of the write-joined FIFO. Its high byte is readable at address 5 and its low byte at address 6.
- R7: rd_remain and wr_remain change in the cycle after the edge at which a pop or push happens, and not before.
- R8: With no read join set, a data-port read returns 0, pops nothing and raises no error, and rd_remain is 0. With no write join set, a data-port write is ignored and wr_remain is 0.
- R9: A read of an empty joined FIFO returns 0 and pops nothing. A write to a full joined FIFO pushes nothing. Either case sets access_err, which stays set until reset.
- R10: The endpoints are independent: bytes pushed into one FIFO are not visible through another.
- R11: After reset, both join registers are 0, all FIFOs are empty, and access_err and cpu_rvalid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 3 | Register address |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after the read |
| cpu_rvalid | output | 1 | Read data valid |
| rd_remain | output | 16 | Bytes held in the read-joined FIFO |
| wr_remain | output | 16 | Free space in the write-joined FIFO |
| access_err | output | 1 | Sticky underrun/overrun flag |

## Verification
The bench writes several bits into a join register at once. A priority encoder that keeps the lowest bit, or one that keeps all of them, would read back the wrong value and route bytes to the wrong endpoint. The bench fills one FIFO completely and then writes once more. A design without the full guard would wrap its pointer and corrupt the oldest byte; the bench sees that in the count and in the first popped value. A design that failed to make the flag sticky would show access_err drop after the overrun. The bench also reads an empty FIFO and reads with no endpoint joined. A design that confused these two cases would either raise the error flag in the harmless case or miss it in the real one. The bench samples the remaining counters on both sides of a push edge, which exposes an off-by-one-cycle update.

// File: rtl/epsel_pkg.sv
package epsel_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RJOIN  = 3'd0;
    localparam logic [ADDR_W-1:0] A_WJOIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DATA   = 3'd2;
    localparam logic [ADDR_W-1:0] A_RREM_H = 3'd3;
    localparam logic [ADDR_W-1:0] A_RREM_L = 3'd4;
    localparam logic [ADDR_W-1:0] A_WREM_H = 3'd5;
    localparam logic [ADDR_W-1:0] A_WREM_L = 3'd6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REG_READ,
        ST_REG_WRITE,
        ST_POP,
        ST_PUSH,
        ST_NULL_READ,
        ST_NULL_WRITE,
        ST_UNDERRUN,
        ST_OVERRUN
    } acc_state_t;

endpackage

// File: rtl/epsel_join_reg.sv
module epsel_join_reg #(
    parameter int NUM_EP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NUM_EP-1:0] req_bits,
    output logic [NUM_EP-1:0] join_q
);

    // Keep only the highest-numbered set bit.
    function automatic logic [NUM_EP-1:0] keep_top(input logic [NUM_EP-1:0] v);
        logic [NUM_EP-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (v[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            join_q <= '0;
        end else if (load) begin
            join_q <= keep_top(req_bits);
        end
    end

endmodule

// File: rtl/epsel_fifo_model.sv
module epsel_fifo_model #(
    parameter int DEPTH  = 260,
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    assign head = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            end
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/epsel_access_fsm.sv
module epsel_access_fsm
    import epsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_joined,
    input  logic              wr_joined,
    input  logic              rd_empty,
    input  logic              wr_full,
    output logic              pop,
    output logic              push,
    output logic              rvalid,
    output logic              err
);

    acc_state_t state_q;
    acc_state_t state_d;
    logic       err_q;

    // Next-state decode from the request of this cycle.
    always_comb begin
        state_d = ST_IDLE;
        if (req_wr) begin
            if (addr == A_DATA) begin
                if (!wr_joined)   state_d = ST_NULL_WRITE;
                else if (wr_full) state_d = ST_OVERRUN;
                else              state_d = ST_PUSH;
            end else begin
                state_d = ST_REG_WRITE;
            end
        end else if (req_rd) begin
            if (addr == A_DATA) begin
                if (!rd_joined)    state_d = ST_NULL_READ;
                else if (rd_empty) state_d = ST_UNDERRUN;
                else               state_d = ST_POP;
            end else begin
                state_d = ST_REG_READ;
            end
        end
    end

    // State register and sticky error.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_UNDERRUN || state_d == ST_OVERRUN) begin
                err_q <= 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        pop  = (state_d == ST_POP);
        push = (state_d == ST_PUSH);
        err  = err_q;
        unique case (state_q)
            ST_REG_READ, ST_POP, ST_NULL_READ, ST_UNDERRUN: rvalid = 1'b1;
            ST_IDLE, ST_REG_WRITE, ST_PUSH,
            ST_NULL_WRITE, ST_OVERRUN:                      rvalid = 1'b0;
            default:                                        rvalid = 1'b0;
        endcase
    end

endmodule

// File: rtl/ep_fifo_port_sel.sv
module ep_fifo_port_sel
    import epsel_pkg::*;
#(
    parameter int NUM_EP     = 4,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 260,
    parameter int REM_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_rvalid,
    output logic [15:0]       rd_remain,
    output logic [15:0]       wr_remain,
    output logic              access_err
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    logic [NUM_EP-1:0] rd_join_q;
    logic [NUM_EP-1:0] wr_join_q;
    logic [DATA_W-1:0] ep_head  [NUM_EP];
    logic [CNT_W-1:0]  ep_count [NUM_EP];
    logic [CNT_W-1:0]  sel_rd_cnt;
    logic [CNT_W-1:0]  sel_wr_cnt;
    logic [DATA_W-1:0] sel_head;
    logic              pop;
    logic              push;
    logic              rd_empty;
    logic              wr_full;
    logic [7:0]        reg_val;
    logic [7:0]        rdata_q;

    epsel_join_reg #(.NUM_EP(NUM_EP)) rjoin_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cpu_wr && cpu_addr == A_RJOIN),
        .req_bits (cpu_wdata[NUM_EP-1:0]),
        .join_q   (rd_join_q)
    );

    epsel_join_reg #(.NUM_EP(NUM_EP)) wjoin_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cpu_wr && cpu_addr == A_WJOIN),
        .req_bits (cpu_wdata[NUM_EP-1:0]),
        .join_q   (wr_join_q)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        epsel_fifo_model #(
            .DEPTH  (FIFO_DEPTH),
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W)
        ) fifo_i (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push && wr_join_q[g]),
            .pop   (pop && rd_join_q[g]),
            .wdata (cpu_wdata[DATA_W-1:0]),
            .head  (ep_head[g]),
            .count (ep_count[g])
        );
    end

    // One-hot AND-OR selection of the joined endpoints.
    always_comb begin
        sel_rd_cnt = '0;
        sel_wr_cnt = '0;
        sel_head   = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            sel_rd_cnt = sel_rd_cnt | (ep_count[i] & {CNT_W{rd_join_q[i]}});
            sel_wr_cnt = sel_wr_cnt | (ep_count[i] & {CNT_W{wr_join_q[i]}});
            sel_head   = sel_head   | (ep_head[i]  & {DATA_W{rd_join_q[i]}});
        end
    end

    assign rd_empty  = (sel_rd_cnt == '0);
    assign wr_full   = (sel_wr_cnt == FULL_CNT);
    assign rd_remain = REM_W'(sel_rd_cnt);
    assign wr_remain = (wr_join_q == '0) ? '0 : REM_W'(FULL_CNT - sel_wr_cnt);

    epsel_access_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_rd    (cpu_rd),
        .req_wr    (cpu_wr),
        .addr      (cpu_addr),
        .rd_joined (rd_join_q != '0),
        .wr_joined (wr_join_q != '0),
        .rd_empty  (rd_empty),
        .wr_full   (wr_full),
        .pop       (pop),
        .push      (push),
        .rvalid    (cpu_rvalid),
        .err       (access_err)
    );

    always_comb begin
        unique case (cpu_addr)
            A_RJOIN:  reg_val = 8'(rd_join_q);
            A_WJOIN:  reg_val = 8'(wr_join_q);
            A_RREM_H: reg_val = rd_remain[15:8];
            A_RREM_L: reg_val = rd_remain[7:0];
            A_WREM_H: reg_val = wr_remain[15:8];
            A_WREM_L: reg_val = wr_remain[7:0];
            default:  reg_val = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (pop) begin
            rdata_q <= 8'(sel_head);
        end else if (cpu_rd && !cpu_wr) begin
            rdata_q <= reg_val;
        end
    end

    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/epsel_checker.sv
module epsel_checker
    import epsel_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [7:0]        cpu_wdata,
    input logic [NUM_EP-1:0] rd_join,
    input logic [NUM_EP-1:0] wr_join,
    input logic [15:0]       rd_remain,
    input logic [15:0]       wr_remain,
    input logic              cpu_rvalid,
    input logic              access_err
);

    logic data_rd;
    logic data_wr;
    assign data_rd = cpu_rd && !cpu_wr && cpu_addr == A_DATA;
    assign data_wr = cpu_wr && cpu_addr == A_DATA;

    assert_rjoin_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_join));

    assert_wjoin_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_join));

    assert_top_bit_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == A_RJOIN && cpu_wdata[NUM_EP-1]) |=> rd_join[NUM_EP-1]);

    assert_pop_drops_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rd_remain != 16'd0) |=> rd_remain == $past(rd_remain) - 16'd1);

    assert_rvalid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr) |=> cpu_rvalid);

    assert_push_takes_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && wr_remain != 16'd0) |=> wr_remain == $past(wr_remain) - 16'd1);

    assert_unjoined_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_join == '0) |-> rd_remain == 16'd0);

    assert_underrun_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rd_join != '0 && rd_remain == 16'd0) |=> access_err);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |=> access_err);

endmodule

bind ep_fifo_port_sel epsel_checker #(.NUM_EP(NUM_EP)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .rd_join    (rd_join_q),
    .wr_join    (wr_join_q),
    .rd_remain  (rd_remain),
    .wr_remain  (wr_remain),
    .cpu_rvalid (cpu_rvalid),
    .access_err (access_err)
);

// File: tb/ep_fifo_port_sel_tb.sv
module ep_fifo_port_sel_tb_top;

    localparam int DEPTH = 260;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic [15:0] rd_remain;
    logic [15:0] wr_remain;
    logic        access_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ep_fifo_port_sel dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_rvalid (cpu_rvalid),
        .rd_remain  (rd_remain),
        .wr_remain  (wr_remain),
        .access_err (access_err)
    );

    // Entry: {req[3:0], is_read, addr[2:0], data_or_expected[7:0]}
    localparam int NV = 18;
    localparam logic [15:0] VEC [NV] = '{
        {4'd1,  1'b0, 3'd0, 8'h00},  // R1 clear read join
        {4'd1,  1'b0, 3'd1, 8'h00},  // R1 clear write join
        {4'd2,  1'b0, 3'd0, 8'h0F},  // R2 all bits requested
        {4'd2,  1'b1, 3'd0, 8'h08},  // R2 only bit 3 kept
        {4'd2,  1'b0, 3'd1, 8'h03},  // R2 bits 0,1 requested
        {4'd2,  1'b1, 3'd1, 8'h02},  // R2 only bit 1 kept
        {4'd4,  1'b0, 3'd2, 8'hA1},  // R4 push to ep1
        {4'd4,  1'b0, 3'd2, 8'hB2},  // R4 push to ep1
        {4'd6,  1'b1, 3'd5, 8'h01},  // R6 free 258 high byte
        {4'd6,  1'b1, 3'd6, 8'h02},  // R6 free 258 low byte
        {4'd1,  1'b0, 3'd0, 8'h02},  // R1 join ep1 for reading
        {4'd5,  1'b1, 3'd4, 8'h02},  // R5 two bytes held
        {4'd5,  1'b1, 3'd3, 8'h00},  // R5 high byte
        {4'd3,  1'b1, 3'd2, 8'hA1},  // R3 oldest first
        {4'd3,  1'b1, 3'd2, 8'hB2},  // R3 destructive pop
        {4'd5,  1'b1, 3'd4, 8'h00},  // R5 drained
        {4'd10, 1'b0, 3'd0, 8'h01},  // R10 join ep0
        {4'd10, 1'b1, 3'd4, 8'h00}   // R10 ep1 bytes not in ep0
    };

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 rvalid", 16'(cpu_rvalid), 16'd0);
        check("R11 err", 16'(access_err), 16'd0);
        check("R11 rd_remain", rd_remain, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(3'd0, d);
        check("R11 read join", 16'(d), 16'd0);
        check("R3 rvalid after read", 16'(cpu_rvalid), 16'd1);

        // R8 no join: write ignored, read yields 0, no pop, no error
        check("R8 wr_remain unjoined", wr_remain, 16'd0);
        bus_write(3'd2, 8'h55);
        bus_read(3'd2, d);
        check("R8 read unjoined", 16'(d), 16'd0);
        check("R8 no error", 16'(access_err), 16'd0);
        bus_write(3'd1, 8'h01);
        check("R8 ignored write left ep0 empty", wr_remain, 16'(DEPTH));

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            v = VEC[i];
            if (v[11]) begin
                bus_read(v[10:8], d);
                check($sformatf("R%0d vector %0d", v[15:12], i), 16'(d), 16'(v[7:0]));
            end else begin
                bus_write(v[10:8], v[7:0]);
            end
        end

        // R7 update timing around a push to ep2
        bus_write(3'd1, 8'h04);
        check("R6 ep2 empty free", wr_remain, 16'(DEPTH));
        @(negedge clk);
        cpu_addr = 3'd2; cpu_wdata = 8'h33; cpu_wr = 1'b1;
        check("R7 no change before edge", wr_remain, 16'(DEPTH));
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R7 change after edge", wr_remain, 16'(DEPTH - 1));

        // R3 pop from ep2, then R9 underrun
        bus_write(3'd0, 8'h04);
        check("R5 ep2 count", rd_remain, 16'd1);
        bus_read(3'd2, d);
        check("R3 pop ep2", 16'(d), 16'h33);
        check("R7 rd_remain after pop", rd_remain, 16'd0);
        check("R9 no error yet", 16'(access_err), 16'd0);
        bus_read(3'd2, d);
        check("R9 underrun data", 16'(d), 16'd0);
        check("R9 underrun flag", 16'(access_err), 16'd1);
        repeat (3) @(negedge clk);
        check("R9 flag sticky", 16'(access_err), 16'd1);

        // R9 overrun on ep3
        bus_write(3'd1, 8'h08);
        for (int k = 0; k < DEPTH; k++) bus_write(3'd2, 8'(k));
        check("R6 full free", wr_remain, 16'd0);
        bus_write(3'd2, 8'hEE);
        check("R9 overrun no push", wr_remain, 16'd0);
        bus_write(3'd0, 8'h08);
        check("R5 full count", rd_remain, 16'(DEPTH));
        bus_read(3'd3, d);
        check("R5 high byte", 16'(d), 16'h01);
        bus_read(3'd4, d);
        check("R5 low byte", 16'(d), 16'h04);
        bus_read(3'd2, d);
        check("R9 oldest intact after overrun", 16'(d), 16'h00);
        check("R9 still flagged", 16'(access_err), 16'd1);

        // R4 simultaneous read+write: only the write
        @(negedge clk);
        cpu_addr = 3'd2; cpu_wdata = 8'h77; cpu_rd = 1'b1; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        check("R4 write wins, no pop", rd_remain, 16'(DEPTH));

        // R11 reset again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 err cleared", 16'(access_err), 16'd0);
        check("R11 remain cleared", rd_remain, 16'd0);
        bus_read(3'd1, d);
        check("R11 write join cleared", 16'(d), 16'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule